// File: doc/BRIEF.md
# Slave-Sensor Trigger Host

This block is the host-side master for an image sensor running in slave mode. On a start command it latches the frame geometry and the sensor's latency mode, emits one frame trigger and then one row trigger per row. It collects each row's pixel words from the sensor's 10-bit data bus. The sensor sends no data-valid strobe, so the block opens its capture window at a latency it computes from the two mode bits. The sensor's mode bits select 147 cycles as the base delay, plus 100 when horizontal averaging is on, minus 8 when black-pixel output is on.

Both trigger pins have a programmable active level. Every pulse lasts a parameterised number of cycles, with a floor of two. A frame trigger never begins sooner than 20 cycles after the most recent row trigger began. A new row trigger is sent only once the previous row has been fully captured. Captured words come out with a valid flag and with start-of-row and start-of-frame markers. A single-cycle done pulse follows the last word of the frame. The host and the sensor share one clock, so master-clock and pixel-clock cycles are the same cycles here.

Top module: `vtg_trigger_host`

## Requirements
- R1: Every row trigger pulse holds its active level for exactly W cycles, where W is the pulse-width parameter raised to 2 if set lower (default W = 3).
- R2: Every frame trigger pulse holds its active level for exactly W cycles.
- R3: The first active cycle of a frame trigger is at least 20 cycles after the first active cycle of the most recent row trigger, including when a new start arrives in the same cycle the done pulse is seen.
- R4: With k the first active cycle of a row trigger, the word captured first is the value on `pix_i` in cycle k+L, and `pix_vld_o` rises in cycle k+L+1, where L = 147 + 100·avg_mode_i − 8·blk_mode_i as latched at start.
- R5: A trigger pin at rest drives the inverse of its polarity bit and drives the polarity bit while active (1 = active high); after reset both pins are at rest and `pix_vld_o` and `done_o` are 0.
- R6: Each row delivers exactly cols words in consecutive cycles with `pix_vld_o` high, each equal to `pix_i` at its capture cycle; `pix_sol_o` is high on the first word of every row and `pix_sof_o` only on the first word of row 0.
- R7: A frame consists of one frame trigger followed by rows row triggers; the first row trigger starts after the frame trigger has ended, and each later row trigger starts only after every word of the previous row has been captured.
- R8: `done_o` is high for exactly one cycle, the cycle after the last valid word of the frame.
- R9: A start command while a frame is in progress is ignored: no extra frame trigger, and geometry or mode inputs changed with it do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared host and sensor clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-frame command, accepted only when idle |
| rows_i | input | ROW_W | Rows per frame, latched on start (0 treated as 1) |
| cols_i | input | COL_W | Words per row, latched on start (0 treated as 1) |
| avg_mode_i | input | 1 | Sensor averaging mode bit, adds 100 to latency |
| blk_mode_i | input | 1 | Sensor black-pixel mode bit, subtracts 8 from latency |
| row_pol_i | input | 1 | Active level of the row trigger; change only in reset |
| frame_pol_i | input | 1 | Active level of the frame trigger; change only in reset |
| frame_trig_o | output | 1 | Frame trigger pin to the sensor |
| row_trig_o | output | 1 | Row trigger pin to the sensor |
| pix_i | input | DATA_W | Pixel bus from the sensor |
| pix_o | output | DATA_W | Captured pixel word |
| pix_vld_o | output | 1 | Captured word is valid |
| pix_sol_o | output | 1 | First word of a row |
| pix_sof_o | output | 1 | First word of a frame |
| done_o | output | 1 | One-cycle pulse after the frame's last word |

## Verification
The hardest situation to reach is a mis-timed capture window, since a data bus without a strobe gives no sign of an off-by-one. The bench's sensor model drives a distinct pattern word only inside the predicted window and a position-dependent junk value everywhere else, so a window shifted by one cycle captures junk that the scoreboard rejects. The gap rule is driven by issuing a new start in the very cycle the done pulse appears. The ignored-start case is driven by a second start mid-frame that also changes the column count.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_GAP   = 2'd1,
    S_FRAME = 2'd2,
    S_ROW   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/vtg_pulse.sv
module vtg_pulse #(
  parameter int PULSE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic pol,
  output logic trig_o,
  output logic active_o
);
  localparam int W  = (PULSE_W < 2) ? 2 : PULSE_W;
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      trig_o <= ~pol;
    end else begin
      if (fire)
        left <= CW'(W);
      else if (left != '0)
        left <= left - CW'(1);
      trig_o <= (fire || left > CW'(1)) ? pol : ~pol;
    end
  end

  assign active_o = (left != '0);
endmodule

// File: rtl/vtg_capture.sv
module vtg_capture #(
  parameter int DATA_W = 10,
  parameter int COL_W  = 11,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              first_row,
  input  logic [COL_W-1:0]  cols,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] pix_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              vld_o,
  output logic              sol_o,
  output logic              sof_o,
  output logic              row_done_o
);
  localparam int NW = ((LAT_W > COL_W) ? LAT_W : COL_W) + 1;

  logic [NW-1:0] cnt;
  logic [NW-1:0] open_at;
  logic [NW-1:0] close_at;
  logic          running;
  logic          sof_arm;
  logic          hit;
  logic          last;

  assign open_at  = NW'(lat);
  assign close_at = open_at + NW'(cols);
  assign hit      = running && (cnt >= open_at) && (cnt < close_at);
  assign last     = running && (cnt == close_at - NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      running    <= 1'b0;
      sof_arm    <= 1'b0;
      pix_o      <= '0;
      vld_o      <= 1'b0;
      sol_o      <= 1'b0;
      sof_o      <= 1'b0;
      row_done_o <= 1'b0;
    end else begin
      if (start) begin
        cnt     <= '0;
        running <= 1'b1;
        sof_arm <= first_row;
      end else if (running) begin
        cnt <= cnt + NW'(1);
        if (last)
          running <= 1'b0;
      end
      if (hit)
        pix_o <= pix_i;
      vld_o      <= hit;
      sol_o      <= hit && (cnt == open_at);
      sof_o      <= hit && (cnt == open_at) && sof_arm;
      row_done_o <= last;
    end
  end
endmodule

// File: rtl/vtg_trigger_host.sv
module vtg_trigger_host
  import vtg_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 11,
  parameter int PULSE_W  = 3,
  parameter int GAP_CYC  = 20,
  parameter int LAT_BASE = 147,
  parameter int LAT_AVG  = 100,
  parameter int LAT_BLK  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic              avg_mode_i,
  input  logic              blk_mode_i,
  input  logic              row_pol_i,
  input  logic              frame_pol_i,
  output logic              frame_trig_o,
  output logic              row_trig_o,
  input  logic [DATA_W-1:0] pix_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              pix_vld_o,
  output logic              pix_sol_o,
  output logic              pix_sof_o,
  output logic              done_o
);
  localparam int LAT_W = $clog2(LAT_BASE + LAT_AVG + 1);
  localparam int GW    = $clog2(GAP_CYC + 1);

  seq_state_t        state;
  logic [ROW_W-1:0]  rows_q;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  cols_q;
  logic [LAT_W-1:0]  lat_q;
  logic [GW-1:0]     since;
  logic              f_fire;
  logic              r_fire;
  logic              f_act;
  logic              r_act;
  logic              row_done;
  logic              last_row;

  assign last_row = (row_idx == rows_q - ROW_W'(1));
  assign f_fire   = (state == S_GAP) && (since >= GW'(GAP_CYC - 1));
  assign r_fire   = ((state == S_FRAME) && !f_act) ||
                    ((state == S_ROW) && row_done && !last_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      rows_q  <= ROW_W'(1);
      cols_q  <= COL_W'(1);
      lat_q   <= LAT_W'(LAT_BASE);
      row_idx <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          rows_q <= (rows_i == '0) ? ROW_W'(1) : rows_i;
          cols_q <= (cols_i == '0) ? COL_W'(1) : cols_i;
          lat_q  <= LAT_W'(LAT_BASE + (avg_mode_i ? LAT_AVG : 0)
                                    - (blk_mode_i ? LAT_BLK : 0));
          state  <= S_GAP;
        end
        S_GAP: if (f_fire) state <= S_FRAME;
        S_FRAME: if (!f_act) begin
          row_idx <= '0;
          state   <= S_ROW;
        end
        S_ROW: if (row_done) begin
          if (last_row) begin
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else begin
            row_idx <= row_idx + ROW_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // cycles since the last row trigger became active, saturating
  always_ff @(posedge clk) begin
    if (rst)
      since <= GW'(GAP_CYC - 1);
    else if (r_fire)
      since <= '0;
    else if (since < GW'(GAP_CYC - 1))
      since <= since + GW'(1);
  end

  vtg_pulse #(.PULSE_W(PULSE_W)) u_frame_pulse (
    .clk(clk), .rst(rst), .fire(f_fire), .pol(frame_pol_i),
    .trig_o(frame_trig_o), .active_o(f_act)
  );

  vtg_pulse #(.PULSE_W(PULSE_W)) u_row_pulse (
    .clk(clk), .rst(rst), .fire(r_fire), .pol(row_pol_i),
    .trig_o(row_trig_o), .active_o(r_act)
  );

  vtg_capture #(.DATA_W(DATA_W), .COL_W(COL_W), .LAT_W(LAT_W)) u_capture (
    .clk(clk), .rst(rst), .start(r_fire), .first_row(state == S_FRAME),
    .cols(cols_q), .lat(lat_q), .pix_i(pix_i), .pix_o(pix_o),
    .vld_o(pix_vld_o), .sol_o(pix_sol_o), .sof_o(pix_sof_o),
    .row_done_o(row_done)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int PULSE_W = 3,
  parameter int GAP_CYC = 20,
  parameter int LAT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_trig_o,
  input logic             row_trig_o,
  input logic             frame_pol_i,
  input logic             row_pol_i,
  input logic             pix_vld_o,
  input logic             pix_sol_o,
  input logic             pix_sof_o,
  input logic             done_o,
  input logic [LAT_W-1:0] lat_q
);
  localparam int W = (PULSE_W < 2) ? 2 : PULSE_W;

  logic        r_on, f_on, r_prev, f_prev;
  logic [15:0] r_run, f_run, since_r;

  assign r_on = (row_trig_o == row_pol_i);
  assign f_on = (frame_trig_o == frame_pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_prev  <= 1'b0;
      f_prev  <= 1'b0;
      r_run   <= '0;
      f_run   <= '0;
      since_r <= 16'(GAP_CYC);
    end else begin
      r_prev  <= r_on;
      f_prev  <= f_on;
      r_run   <= r_on ? r_run + 16'd1 : 16'd0;
      f_run   <= f_on ? f_run + 16'd1 : 16'd0;
      if (r_on && !r_prev)
        since_r <= 16'd1;
      else if (since_r != 16'hFFFF)
        since_r <= since_r + 16'd1;
    end
  end

  assert_row_width_R1: assert property (@(posedge clk) disable iff (rst)
    (!r_on && r_run != 16'd0) |-> (r_run == 16'(W)));

  assert_frame_width_R2: assert property (@(posedge clk) disable iff (rst)
    (!f_on && f_run != 16'd0) |-> (f_run == 16'(W)));

  assert_frame_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (f_on && !f_prev) |-> (since_r >= 16'(GAP_CYC)));

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    pix_sol_o |-> (since_r == 16'(lat_q) + 16'd1));

  assert_markers_R6: assert property (@(posedge clk) disable iff (rst)
    pix_sof_o |-> (pix_sol_o && pix_vld_o));

  assert_sol_valid_R6: assert property (@(posedge clk) disable iff (rst)
    pix_sol_o |-> pix_vld_o);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(f_on && r_on));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_pixel_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(pix_vld_o));
endmodule

bind vtg_trigger_host vtg_checker #(
  .PULSE_W(PULSE_W), .GAP_CYC(GAP_CYC), .LAT_W(LAT_W)
) u_vtg_checker (
  .clk(clk), .rst(rst), .frame_trig_o(frame_trig_o), .row_trig_o(row_trig_o),
  .frame_pol_i(frame_pol_i), .row_pol_i(row_pol_i), .pix_vld_o(pix_vld_o),
  .pix_sol_o(pix_sol_o), .pix_sof_o(pix_sof_o), .done_o(done_o), .lat_q(lat_q)
);

// File: tb/tb_vtg_trigger_host.sv
`timescale 1ns/1ps
module tb_vtg_trigger_host;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [9:0] rows_i = 10'd1;
  logic [10:0] cols_i = 11'd1;
  logic       avg_mode_i = 1'b0, blk_mode_i = 1'b0;
  logic       row_pol_i = 1'b1, frame_pol_i = 1'b1;
  logic       frame_trig_o, row_trig_o;
  logic [9:0] pix_i = '0;
  logic [9:0] pix_o;
  logic       pix_vld_o, pix_sol_o, pix_sof_o, done_o;

  vtg_trigger_host #(.PULSE_W(W)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int rk = 0, row_num = -1, fid = 0, lat_e = 147, cols_e = 1, rows_e = 1;
  int r_len = 0, f_len = 0, frame_cnt = 0, row_cnt = 0, done_cnt = 0;
  int pix_cnt = 0, row_pix = 0, last_vld = 0, exp_total = 0;
  bit ra_prev = 0, fa_prev = 0, row_seen = 0;
  logic [11:0] sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [9:0] pat(input int f, input int r, input int c);
    return 10'((r * 37 + c * 11 + f * 101) & 10'h3FF);
  endfunction

  // sensor model, scoreboard monitor and pin timing checks
  always @(negedge clk) begin
    if (rst) begin
      ra_prev = 0; fa_prev = 0; r_len = 0; f_len = 0;
    end else begin
      bit ra, fa;
      int j;
      ra = (row_trig_o == row_pol_i);
      fa = (frame_trig_o == frame_pol_i);
      if (pix_vld_o) begin
        logic [11:0] e;
        if (sb.size() == 0) begin
          chk(0, "R6 unexpected word", int'(pix_o), -1);
        end else begin
          e = sb.pop_front();
          chk(pix_o == e[9:0], "R6 data", int'(pix_o), int'(e[9:0]));
          chk(pix_sol_o == e[10], "R6 row marker", int'(pix_sol_o), int'(e[10]));
          chk(pix_sof_o == e[11], "R6 frame marker", int'(pix_sof_o), int'(e[11]));
          if (e[10]) chk(cyc - rk == lat_e + 1, "R4 latency", cyc - rk, lat_e + 1);
        end
        last_vld = cyc; pix_cnt++; row_pix++;
      end
      if (done_o) begin
        done_cnt++;
        chk(cyc == last_vld + 1, "R8 done timing", cyc, last_vld + 1);
        chk(pix_cnt == exp_total, "R8 words before done", pix_cnt, exp_total);
      end
      if (fa && !fa_prev) begin
        if (row_seen) chk(cyc - rk >= 20, "R3 frame gap", cyc - rk, 20);
        frame_cnt++; fid++; row_num = -1;
      end
      if (ra && !ra_prev) begin
        chk(!fa, "R7 row during frame trigger", int'(fa), 0);
        if (row_num >= 0) chk(row_pix == cols_e, "R7 previous row complete", row_pix, cols_e);
        rk = cyc; row_num++; row_seen = 1; row_cnt++; row_pix = 0;
      end
      if (ra) r_len++;
      else if (ra_prev) begin chk(r_len == W, "R1 row width", r_len, W); r_len = 0; end
      if (fa) f_len++;
      else if (fa_prev) begin chk(f_len == W, "R2 frame width", f_len, W); f_len = 0; end
      ra_prev = ra; fa_prev = fa;
      j = cyc - rk;
      if (row_seen && row_num >= 0 && j >= lat_e && j < lat_e + cols_e) begin
        pix_i = pat(fid, row_num, j - lat_e);
        sb.push_back({(row_num == 0 && j == lat_e), (j == lat_e), pix_i});
      end else begin
        pix_i = 10'h155 ^ 10'(j);
      end
    end
  end

  task automatic set_pol(input bit rp, input bit fp);
    if (rp != row_pol_i || fp != frame_pol_i) begin
      @(negedge clk); rst = 1; row_pol_i = rp; frame_pol_i = fp;
      repeat (3) @(negedge clk);
      rst = 0;
      repeat (2) @(negedge clk);
      chk(row_trig_o == ~rp, "R5 row idle level", int'(row_trig_o), int'(~rp));
      chk(frame_trig_o == ~fp, "R5 frame idle level", int'(frame_trig_o), int'(~fp));
    end
  endtask

  task automatic run_frame(input int rows, input int cols, input bit avg, input bit blk,
                           input bit poke, input bit no_sync);
    int f0, r0, d0, t;
    if (!no_sync) @(negedge clk);
    f0 = frame_cnt; r0 = row_cnt; d0 = done_cnt;
    rows_i = 10'(rows); cols_i = 11'(cols); avg_mode_i = avg; blk_mode_i = blk;
    rows_e = rows; cols_e = cols; lat_e = 147 + 100 * int'(avg) - 8 * int'(blk);
    exp_total = rows * cols; pix_cnt = 0;
    start_i = 1; @(negedge clk); start_i = 0;
    if (poke) begin
      repeat (200) @(negedge clk);
      cols_i = 11'(cols + 2); avg_mode_i = ~avg; start_i = 1;
      @(negedge clk); start_i = 0;
    end
    t = 0;
    while (done_cnt == d0 && t < 50000) begin @(negedge clk); t++; end
    chk(t < 50000, "R8 watchdog", t, 50000);
    chk(frame_cnt - f0 == 1, "R7/R9 one frame trigger", frame_cnt - f0, 1);
    chk(row_cnt - r0 == rows, "R7 row trigger count", row_cnt - r0, rows);
    chk(sb.size() == 0, "R6 all words delivered", sb.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(pix_vld_o == 0, "R5 reset valid", int'(pix_vld_o), 0);
    chk(done_o == 0, "R5 reset done", int'(done_o), 0);
    chk(row_trig_o == 0, "R5 reset row idle", int'(row_trig_o), 0);
    chk(frame_trig_o == 0, "R5 reset frame idle", int'(frame_trig_o), 0);
    run_frame(3, 5, 0, 0, 0, 0);
    run_frame(2, 4, 1, 0, 0, 0);
    set_pol(0, 0);
    run_frame(4, 3, 0, 1, 0, 0);
    set_pol(0, 1);
    run_frame(2, 6, 1, 1, 1, 0);
    begin
      int f1;
      f1 = frame_cnt;
      repeat (300) @(negedge clk);
      chk(frame_cnt == f1, "R9 ignored start left no frame", frame_cnt, f1);
    end
    run_frame(2, 2, 0, 0, 0, 0);
    run_frame(1, 1, 0, 0, 0, 1);
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule